// File: doc/BRIEF.md
# Indexed Super I/O Configuration Port

This block is a bank of byte-wide configuration registers that a host reaches through two neighbouring addresses on a simple I/O bus. A write to the index address picks one of 256 register slots. Later reads and writes on the data address act on that slot.

Only a sparse set of slots in the top window (0xE0 to 0xFF) can be written. Every other index keeps its value no matter what is written to it. Six slots load fixed values at reset. Two of them hold the serial-port base settings, and each accepts only the single value it already holds.

One bit of an external control byte switches the whole port pair on or off. While the bit is clear, the block ignores both addresses completely. Each bus access finishes in one cycle. The acknowledge and read data come out of registers on the clock edge that samples the strobe.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the index is 0x00. Slot 0xE0 reads 0x3C, 0xE2 reads 0x03, 0xE3 reads 0xFC, 0xE6 reads 0xDE, 0xE7 reads 0xFE and 0xE8 reads 0xBE. Every other slot reads 0x00.
- R2: A write to address 0x3F0 stores the 8-bit write data as the current index. A read of 0x3F0 returns the current index.
- R3: A read of address 0x3F1 returns the slot selected by the current index. The acknowledge and read data are registered: they are valid in the cycle after the cycle in which the strobe is sampled.
- R4: A write to 0x3F1 updates the selected slot when the index is 0xE0–0xE3, 0xE6, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 or 0xFC.
- R5: A write to 0x3F1 has no effect when the index is 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB or 0xFD–0xFF.
- R6: Slot 0xE7 accepts only the value 0xFE and slot 0xE8 accepts only 0xBE. A write of any other value leaves the slot unchanged.
- R7: The port pair responds only while bit 1 of `ctrl_byte` is 1. While that bit is 0, an access to either address gives no acknowledge and read data 0x00, and changes neither the index nor any slot.
- R8: The read data is 0x00 whenever the acknowledge is low. A write that is acknowledged returns read data 0x00.
- R9: An access to any address other than 0x3F0 and 0x3F1 gets no acknowledge and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_byte | input | 8 | External control byte; bit 1 enables the port pair |
| bus_addr | input | 16 | I/O address of the access |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bus_ack | output | 1 | Registered acknowledge for an access the block claims |

## Verification
The bench drives random index values biased toward the 0xE0–0xFF window, where writable and read-only slots sit side by side. It mixes these with random data, random addresses inside and outside the pair, and the enable bit toggled now and then. This shows whether the write mask is applied per index and not per range. Directed cases cover what random traffic would rarely reach: the reset contents, the two locked serial-base slots written with both the accepted and a rejected value, and a disabled window followed by a readback of the index. Random read-only writes followed by readbacks show that the mask holds even at indices next to writable slots.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int IDX_W  = 8;
  localparam int DATA_W = 8;

  localparam logic [IDX_W-1:0]  UART_A_IDX = 8'hE7;
  localparam logic [IDX_W-1:0]  UART_B_IDX = 8'hE8;
  localparam logic [DATA_W-1:0] UART_A_VAL = 8'hFE;
  localparam logic [DATA_W-1:0] UART_B_VAL = 8'hBE;

  // Indices that software may alter through the data port.
  function automatic logic slot_writable(input logic [IDX_W-1:0] i);
    logic w;
    case (i)
      8'hE0, 8'hE1, 8'hE2, 8'hE3,
      8'hE6, 8'hE7, 8'hE8,
      8'hEE, 8'hEF, 8'hF0, 8'hF1, 8'hF2,
      8'hF4, 8'hF6, 8'hF8, 8'hFC: w = 1'b1;
      default:                    w = 1'b0;
    endcase
    return w;
  endfunction

  // Power-on contents of each slot.
  function automatic logic [DATA_W-1:0] slot_init(input logic [IDX_W-1:0] i);
    logic [DATA_W-1:0] v;
    case (i)
      8'hE0:   v = 8'h3C;
      8'hE2:   v = 8'h03;
      8'hE3:   v = 8'hFC;
      8'hE6:   v = 8'hDE;
      8'hE7:   v = UART_A_VAL;
      8'hE8:   v = UART_B_VAL;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  // Serial-base slots take only their one supported value.
  function automatic logic value_allowed(input logic [IDX_W-1:0] i,
                                         input logic [DATA_W-1:0] d);
    logic ok;
    if (i == UART_A_IDX)      ok = (d == UART_A_VAL);
    else if (i == UART_B_IDX) ok = (d == UART_B_VAL);
    else                      ok = 1'b1;
    return ok;
  endfunction

endpackage

// File: rtl/sio_port_decode.sv
module sio_port_decode #(
  parameter int              ADDR_W   = 16,
  parameter logic [15:0]     IDX_PORT = 16'h03F0,
  parameter logic [15:0]     DAT_PORT = 16'h03F1,
  parameter int              CTRL_W   = 8,
  parameter int              EN_BIT   = 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [CTRL_W-1:0] ctrl,
  output logic              idx_wr,
  output logic              idx_rd,
  output logic              dat_wr,
  output logic              dat_rd,
  output logic              claim
);

  logic en;
  logic at_idx;
  logic at_dat;
  logic unused_ctrl;

  assign unused_ctrl = ^ctrl;
  assign en     = ctrl[EN_BIT];
  assign at_idx = en && (addr == ADDR_W'(IDX_PORT));
  assign at_dat = en && (addr == ADDR_W'(DAT_PORT));

  assign idx_wr = at_idx && wr;
  assign idx_rd = at_idx && rd && !wr;
  assign dat_wr = at_dat && wr;
  assign dat_rd = at_dat && rd && !wr;
  assign claim  = (at_idx || at_dat) && (rd || wr);

endmodule

// File: rtl/sio_index_reg.sv
module sio_index_reg #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [IDX_W-1:0] d,
  output logic [IDX_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end

  AST_IDX_LOADS: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && ld) |-> (q == $past(d)));  // R2

  AST_IDX_HOLDS: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !ld) |-> $stable(q));  // R7

endmodule

// File: rtl/sio_reg_bank.sv
module sio_reg_bank
  import sio_cfg_pkg::*;
#(
  parameter int WIN_BASE  = 224,
  parameter int WIN_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int WIN_AW = (WIN_DEPTH > 1) ? $clog2(WIN_DEPTH) : 1;

  logic [DATA_W-1:0] slot_q [WIN_DEPTH];
  logic              in_win;
  logic [WIN_AW-1:0] off;

  assign in_win = (idx >= IDX_W'(WIN_BASE));
  assign off    = WIN_AW'(idx - IDX_W'(WIN_BASE));

  for (genvar k = 0; k < WIN_DEPTH; k++) begin : g_slot
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(WIN_BASE + k);
    if (slot_writable(SLOT)) begin : g_rw
      always_ff @(posedge clk) begin
        if (rst)
          slot_q[k] <= slot_init(SLOT);
        else if (we && idx == SLOT && value_allowed(SLOT, wdata))
          slot_q[k] <= wdata;
      end
      if (SLOT == UART_A_IDX) begin : g_lock_a
        AST_UART_A_LOCKED: assert property (@(posedge clk) disable iff (rst)
          $past(!rst) |-> (slot_q[k] == UART_A_VAL));  // R6
      end
      if (SLOT == UART_B_IDX) begin : g_lock_b
        AST_UART_B_LOCKED: assert property (@(posedge clk) disable iff (rst)
          $past(!rst) |-> (slot_q[k] == UART_B_VAL));  // R6
      end
    end else begin : g_ro
      assign slot_q[k] = slot_init(SLOT);
    end
  end

  assign rdata = in_win ? slot_q[off] : '0;

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] IDX_PORT  = 16'h03F0,
  parameter logic [15:0] DAT_PORT  = 16'h03F1,
  parameter int          EN_BIT    = 1,
  parameter int          WIN_BASE  = 224,
  parameter int          WIN_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        ctrl_byte,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_ack
);

  logic              idx_wr, idx_rd, dat_wr, dat_rd, claim;
  logic [IDX_W-1:0]  cur_idx;
  logic [DATA_W-1:0] bank_rdata;
  logic              bank_we;
  logic [DATA_W-1:0] rd_next;

  sio_port_decode #(
    .ADDR_W  (ADDR_W),
    .IDX_PORT(IDX_PORT),
    .DAT_PORT(DAT_PORT),
    .CTRL_W  (8),
    .EN_BIT  (EN_BIT)
  ) dec_i (
    .addr  (bus_addr),
    .rd    (bus_rd),
    .wr    (bus_wr),
    .ctrl  (ctrl_byte),
    .idx_wr(idx_wr),
    .idx_rd(idx_rd),
    .dat_wr(dat_wr),
    .dat_rd(dat_rd),
    .claim (claim)
  );

  sio_index_reg #(.IDX_W(IDX_W)) idx_i (
    .clk(clk),
    .rst(rst),
    .ld (idx_wr),
    .d  (bus_wdata),
    .q  (cur_idx)
  );

  assign bank_we = dat_wr && slot_writable(cur_idx);

  sio_reg_bank #(
    .WIN_BASE (WIN_BASE),
    .WIN_DEPTH(WIN_DEPTH)
  ) bank_i (
    .clk  (clk),
    .rst  (rst),
    .we   (bank_we),
    .idx  (cur_idx),
    .wdata(bus_wdata),
    .rdata(bank_rdata)
  );

  always_comb begin
    rd_next = '0;
    if (idx_rd)      rd_next = cur_idx;
    else if (dat_rd) rd_next = bank_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= claim;
      bus_rdata <= rd_next;
    end
  end

  AST_ACK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> $past(ctrl_byte[EN_BIT]));  // R7

  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata != '0) |-> bus_ack);  // R8

  AST_WRITE_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && bus_wr) |-> (bus_rdata == '0));  // R8

  AST_FOREIGN_ADDR_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && bus_addr != ADDR_W'(IDX_PORT) && bus_addr != ADDR_W'(DAT_PORT))
      |-> !bus_ack);  // R9

endmodule

// File: tb/sio_cfg_port_tb_top.sv
`timescale 1ns/1ps
module sio_cfg_port_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  ctrl_byte;
  logic [15:0] bus_addr;
  logic        bus_rd, bus_wr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        bus_ack;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  logic [7:0] m_mem [256];
  logic [7:0] m_idx;

  always #4 clk = ~clk;

  sio_cfg_port dut_i (
    .clk(clk), .rst(rst), .ctrl_byte(ctrl_byte), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  function automatic bit m_writable(input logic [7:0] i);
    if (i < 8'hE0) return 0;
    if (i inside {8'hE4, 8'hE5, 8'hF3, 8'hF5, 8'hF7}) return 0;
    if (i >= 8'hE9 && i <= 8'hED) return 0;
    if (i >= 8'hF9 && i <= 8'hFB) return 0;
    if (i >= 8'hFD) return 0;
    return 1;
  endfunction

  function automatic bit m_accepts(input logic [7:0] i, input logic [7:0] d);
    if (i == 8'hE7) return d == 8'hFE;
    if (i == 8'hE8) return d == 8'hBE;
    return 1;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
    m_mem[8'hE0] = 8'h3C; m_mem[8'hE2] = 8'h03; m_mem[8'hE3] = 8'hFC;
    m_mem[8'hE6] = 8'hDE; m_mem[8'hE7] = 8'hFE; m_mem[8'hE8] = 8'hBE;
    m_idx = 8'h00;
  endtask

  // One access: drive at negedge, result registered at the next posedge, sample at the following negedge.
  task automatic access(input logic [15:0] a, input bit w, input logic [7:0] d, input string tag);
    bit         en;
    logic [7:0] exp_rd;
    bit         exp_ack;
    en      = ctrl_byte[1];
    exp_ack = en && (a == 16'h03F0 || a == 16'h03F1);
    exp_rd  = 8'h00;
    if (exp_ack && !w) exp_rd = (a == 16'h03F0) ? m_idx : m_mem[m_idx];
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_rd = !w; bus_wdata = d;
    @(negedge clk);
    check({tag, " ack"}, {7'd0, bus_ack}, {7'd0, exp_ack});
    check({tag, " rdata"}, bus_rdata, exp_rd);
    bus_wr = 0; bus_rd = 0;
    if (exp_ack && w) begin
      if (a == 16'h03F0) m_idx = d;
      else if (m_writable(m_idx) && m_accepts(m_idx, d)) m_mem[m_idx] = d;
    end
  endtask

  task automatic rd_slot(input logic [7:0] i, input string tag);
    access(16'h03F0, 1, i, tag);
    access(16'h03F1, 0, 8'h00, tag);
  endtask

  task automatic wr_slot(input logic [7:0] i, input logic [7:0] d, input string tag);
    access(16'h03F0, 1, i, tag);
    access(16'h03F1, 1, d, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    rst = 1; ctrl_byte = 8'h02; bus_addr = 0; bus_rd = 0; bus_wr = 0; bus_wdata = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    check("R8 idle rdata", bus_rdata, 8'h00);

    // R1: reset contents and index
    access(16'h03F0, 0, 8'h00, "R1 idx");
    foreach (m_mem[i]) if (i >= 8'hDE) rd_slot(8'(i), "R1 slot");
    rd_slot(8'h00, "R1 low");

    // R2: index load and readback
    access(16'h03F0, 1, 8'hA5, "R2 load");
    access(16'h03F0, 0, 8'h00, "R2 readback");

    // R4 / R3: writable slots
    wr_slot(8'hE1, 8'h5A, "R4 E1"); rd_slot(8'hE1, "R3 E1");
    wr_slot(8'hFC, 8'h77, "R4 FC"); rd_slot(8'hFC, "R3 FC");
    wr_slot(8'hE0, 8'h00, "R4 E0"); rd_slot(8'hE0, "R3 E0");

    // R5: read-only indices ignore writes
    wr_slot(8'h10, 8'hFF, "R5 10"); rd_slot(8'h10, "R5 10");
    wr_slot(8'hE4, 8'h11, "R5 E4"); rd_slot(8'hE4, "R5 E4");
    wr_slot(8'hFF, 8'h22, "R5 FF"); rd_slot(8'hFF, "R5 FF");
    wr_slot(8'hDF, 8'h33, "R5 DF"); rd_slot(8'hDF, "R5 DF");

    // R6: locked serial-base slots
    wr_slot(8'hE7, 8'h12, "R6 E7 bad"); rd_slot(8'hE7, "R6 E7");
    wr_slot(8'hE7, 8'hFE, "R6 E7 ok");  rd_slot(8'hE7, "R6 E7");
    wr_slot(8'hE8, 8'h00, "R6 E8 bad"); rd_slot(8'hE8, "R6 E8");

    // R7: disabled port pair
    access(16'h03F0, 1, 8'hE2, "R7 set");
    ctrl_byte = 8'hFD;
    access(16'h03F0, 1, 8'hE1, "R7 idx wr off");
    access(16'h03F1, 1, 8'h99, "R7 dat wr off");
    access(16'h03F1, 0, 8'h00, "R7 dat rd off");
    ctrl_byte = 8'h02;
    access(16'h03F0, 0, 8'h00, "R7 idx kept");
    access(16'h03F1, 0, 8'h00, "R7 slot kept");

    // R9: foreign addresses
    access(16'h02F0, 1, 8'h44, "R9 wr");
    access(16'h03F2, 0, 8'h00, "R9 rd");
    access(16'h03F0, 0, 8'h00, "R9 idx kept");

    // Random traffic
    for (int n = 0; n < 600; n++) begin
      logic [15:0] a;
      logic [7:0]  d;
      bit          w;
      int          sel;
      ctrl_byte = ($urandom % 10 == 0) ? (8'($urandom) & 8'hFD) : (8'($urandom) | 8'h02);
      sel = $urandom % 10;
      a = (sel < 4) ? 16'h03F0 : (sel < 9) ? 16'h03F1 : 16'($urandom);
      w = $urandom % 2;
      d = 8'($urandom);
      if (a == 16'h03F0 && w && ($urandom % 4 != 0)) d = 8'hE0 | 8'(d[4:0]);
      if (!ctrl_byte[1])                         access(a, w, d, "R7 rand");
      else if (a != 16'h03F0 && a != 16'h03F1)   access(a, w, d, "R9 rand");
      else if (a == 16'h03F0)                    access(a, w, d, "R2 rand");
      else if (!w)                               access(a, w, d, "R3 rand");
      else if (!m_writable(m_idx))               access(a, w, d, "R5 rand");
      else if (m_idx == 8'hE7 || m_idx == 8'hE8) access(a, w, d, "R6 rand");
      else                                       access(a, w, d, "R4 rand");
    end
    ctrl_byte = 8'h02;
    foreach (m_mem[i]) if (i >= 8'hE0) rd_slot(8'(i), "R5 final");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule